// File: doc/BRIEF.md
# Strap Capture and Clock Select Control

This block sits between a set of dual-purpose pads and the clock synthesis logic of a clock generator. While power-on reset is held, the pads are inputs: on every clock edge in reset the block records their levels as a frequency-select strap word. When reset ends, the block turns the pads around to drive clocks and keeps the recorded word unchanged until the next power-on reset. The recorded word is offered for read-back in inverted form.

From a configuration control byte, the block picks the active 5-bit frequency code. That code comes either from the recorded straps or from a software field held in the same byte. The byte also supplies the spread-spectrum and tristate-all controls. The block turns per-output enable bits into gated enables. Each gated enable changes only while its clock is low, so no shortened pulse can appear. Outputs marked as free-running ignore their enable bit. A divide select for the interrupt-controller clock is registered here as well. Synthesis of the actual frequencies lies outside this block.

Top module: `fsel_ctrl`

## Requirements
- R1: On each rising edge of `clk` with `rst` high, `strap_pin` is captured. From that edge on, `strap_rb` shows the bitwise inverse of the captured levels.
- R2: After `rst` falls, the captured strap word never changes, whatever `strap_pin` does, until `rst` is raised again.
- R3: `pin_dir_out` is 0 (pads are inputs) after any edge that samples `rst` high. It is 1 (pads drive clocks) after any edge that samples `rst` low.
- R4: When `ctrl_byte` bit 3 is 0, `freq_code` equals the captured strap levels, not inverted. It is updated one edge after the control byte is sampled.
- R5: When `ctrl_byte` bit 3 is 1, `freq_code` equals {`ctrl_byte`[2], `ctrl_byte`[7:4]}, with bit 2 as the code's most significant bit. It is updated one edge after the control byte is sampled.
- R6: `spread_en` follows `ctrl_byte` bit 1 (1 = ±0.25% center spread), and `tristate_all` follows `ctrl_byte` bit 0 (1 = all outputs high impedance). Each has a latency of one edge.
- R7: For an output that is not free-running, `oe_bits[i]` = 1 enables it and 0 disables it, and a disabled output is held low. `out_en[i]` takes the value of `oe_bits[i]` only on an edge where `out_lvl[i]` is 0. Otherwise it holds.
- R8: An output whose `FREE_MASK` bit is set has `out_en` = 1 after every edge out of reset, whatever its enable bit.
- R9: `apic_div2` follows `apic_half_sel` with a latency of one edge. A value of 1 selects half the PCI clock rate and 0 selects the full PCI rate.
- R10: An edge in reset sets `freq_code`, `spread_en`, `tristate_all` and `out_en` to 0, and sets `apic_div2` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| strap_pin | input | 5 | Pad levels seen during reset |
| ctrl_byte | input | 8 | Control byte: code field, source select, spread, tristate |
| oe_bits | input | N_OUT | Per-output enable register bits (1 = enabled) |
| out_lvl | input | N_OUT | Present level of each output clock |
| apic_half_sel | input | 1 | Interrupt-controller clock divide select |
| pin_dir_out | output | 1 | 1 = pads drive clocks, 0 = pads are inputs |
| strap_rb | output | 5 | Inverted captured strap word for read-back |
| freq_code | output | 5 | Active frequency code |
| spread_en | output | 1 | Spread-spectrum enable |
| tristate_all | output | 1 | Float every output |
| apic_div2 | output | 1 | 1 = interrupt clock at half PCI rate |
| out_en | output | N_OUT | Glitch-free gated enables |

## Verification
The bench builds the block with six outputs, and the top one is marked free-running. This puts the gated and the free-running cases side by side in one run: the bench drives a low enable bit to both and sees only the gated output drop. The bench drives each output's clock level directly. That lets it hold a level high across an enable change, confirm the hold, and then release it. The bench applies a second power-on reset with different strap levels, which shows that a new capture happens only under reset.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int CODE_W     = 5;
  localparam int BYTE_W     = 8;
  localparam int SRC_BIT    = 3;
  localparam int SPREAD_BIT = 1;
  localparam int TRI_BIT    = 0;
  localparam int SW_MSB_BIT = 2;
  localparam int SW_LO_TOP  = 7;
  localparam int SW_LO_BOT  = 4;

  function automatic logic [CODE_W-1:0] sw_code(input logic [BYTE_W-1:0] b);
    return {b[SW_MSB_BIT], b[SW_LO_TOP:SW_LO_BOT]};
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_lvl,
  output logic [W-1:0] cap_n,
  output logic         drive_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_n      <= ~pin_lvl;
      drive_mode <= 1'b0;
    end else begin
      drive_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/code_select.sv
module code_select
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] ctrl,
  input  logic [CODE_W-1:0] strap_lvl,
  output logic [CODE_W-1:0] code,
  output logic              spread,
  output logic              float_all
);
  logic [CODE_W-1:0] next_code;

  always_comb begin
    next_code = ctrl[SRC_BIT] ? sw_code(ctrl) : strap_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= '0;
      spread    <= 1'b0;
      float_all <= 1'b0;
    end else begin
      code      <= next_code;
      spread    <= ctrl[SPREAD_BIT];
      float_all <= ctrl[TRI_BIT];
    end
  end
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl #(
  parameter int             N    = 4,
  parameter logic [N-1:0]   FREE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_en,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] en
);
  wire unused_free = ^((req_en | lvl) & FREE);

  for (genvar i = 0; i < N; i++) begin : g_out
    if (FREE[i]) begin : g_free
      always_ff @(posedge clk) begin
        if (rst) en[i] <= 1'b0;
        else     en[i] <= 1'b1;
      end
    end else begin : g_gated
      always_ff @(posedge clk) begin
        if (rst)         en[i] <= 1'b0;
        else if (!lvl[i]) en[i] <= req_en[i];
      end
    end
  end
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int               N_OUT     = 20,
  parameter logic [N_OUT-1:0] FREE_MASK = 20'h80000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] strap_pin,
  input  logic [BYTE_W-1:0] ctrl_byte,
  input  logic [N_OUT-1:0]  oe_bits,
  input  logic [N_OUT-1:0]  out_lvl,
  input  logic              apic_half_sel,
  output logic              pin_dir_out,
  output logic [CODE_W-1:0] strap_rb,
  output logic [CODE_W-1:0] freq_code,
  output logic              spread_en,
  output logic              tristate_all,
  output logic              apic_div2,
  output logic [N_OUT-1:0]  out_en
);
  logic [CODE_W-1:0] cap_n;

  strap_latch #(.W(CODE_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .pin_lvl   (strap_pin),
    .cap_n     (cap_n),
    .drive_mode(pin_dir_out)
  );

  assign strap_rb = cap_n;

  code_select u_sel (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl_byte),
    .strap_lvl(~cap_n),
    .code     (freq_code),
    .spread   (spread_en),
    .float_all(tristate_all)
  );

  gate_ctrl #(.N(N_OUT), .FREE(FREE_MASK)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .req_en(oe_bits),
    .lvl   (out_lvl),
    .en    (out_en)
  );

  always_ff @(posedge clk) begin
    if (rst) apic_div2 <= 1'b1;
    else     apic_div2 <= apic_half_sel;
  end
endmodule

// File: rtl/fsel_ctrl_chk.sv
module fsel_ctrl_chk
  import fsel_pkg::*;
#(
  parameter int               N_OUT     = 20,
  parameter logic [N_OUT-1:0] FREE_MASK = 20'h80000
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] ctrl_byte,
  input logic [N_OUT-1:0]  oe_bits,
  input logic [N_OUT-1:0]  out_lvl,
  input logic              apic_half_sel,
  input logic              pin_dir_out,
  input logic [CODE_W-1:0] strap_rb,
  input logic [CODE_W-1:0] freq_code,
  input logic              spread_en,
  input logic              tristate_all,
  input logic              apic_div2,
  input logic [N_OUT-1:0]  out_en
);
  wire unused_chk = ^((oe_bits | out_lvl) & FREE_MASK);

  a_r2_strap_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_rb));

  a_r3_pads_input: assert property (@(posedge clk)
    rst |=> !pin_dir_out);

  a_r3_pads_drive: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pin_dir_out);

  a_r4_strap_code: assert property (@(posedge clk) disable iff (rst)
    !ctrl_byte[SRC_BIT] |=> (freq_code == ~$past(strap_rb)));

  a_r5_sw_code: assert property (@(posedge clk) disable iff (rst)
    ctrl_byte[SRC_BIT] |=>
      (freq_code == {$past(ctrl_byte[SW_MSB_BIT]), $past(ctrl_byte[SW_LO_TOP:SW_LO_BOT])}));

  a_r6_spread: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (spread_en == $past(ctrl_byte[SPREAD_BIT])));

  a_r6_float: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (tristate_all == $past(ctrl_byte[TRI_BIT])));

  a_r8_free_runs: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((out_en & FREE_MASK) == FREE_MASK));

  a_r9_apic: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (apic_div2 == $past(apic_half_sel)));

  a_r10_reset_vals: assert property (@(posedge clk)
    rst |=> (freq_code == '0 && !spread_en && !tristate_all && out_en == '0 && apic_div2));

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    if (!FREE_MASK[i]) begin : g_gated
      a_r7_hold_high: assert property (@(posedge clk) disable iff (rst)
        out_lvl[i] |=> $stable(out_en[i]));
      a_r7_follow_low: assert property (@(posedge clk) disable iff (rst)
        !out_lvl[i] |=> (out_en[i] == $past(oe_bits[i])));
    end
  end
endmodule

bind fsel_ctrl fsel_ctrl_chk #(.N_OUT(N_OUT), .FREE_MASK(FREE_MASK)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctrl_byte    (ctrl_byte),
  .oe_bits      (oe_bits),
  .out_lvl      (out_lvl),
  .apic_half_sel(apic_half_sel),
  .pin_dir_out  (pin_dir_out),
  .strap_rb     (strap_rb),
  .freq_code    (freq_code),
  .spread_en    (spread_en),
  .tristate_all (tristate_all),
  .apic_div2    (apic_div2),
  .out_en       (out_en)
);

// File: tb/fsel_ctrl_test.sv
module fsel_ctrl_test;
  localparam int         N  = 6;
  localparam logic [5:0] FM = 6'b100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] strap_pin = 5'b10110;
  logic [7:0] ctrl_byte = 8'h00;
  logic [N-1:0] oe_bits = '0;
  logic [N-1:0] out_lvl = '0;
  logic       apic_half_sel = 1'b1;
  logic       pin_dir_out, spread_en, tristate_all, apic_div2;
  logic [4:0] strap_rb, freq_code;
  logic [N-1:0] out_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fsel_ctrl #(.N_OUT(N), .FREE_MASK(FM)) uut (
    .clk(clk), .rst(rst), .strap_pin(strap_pin), .ctrl_byte(ctrl_byte),
    .oe_bits(oe_bits), .out_lvl(out_lvl), .apic_half_sel(apic_half_sel),
    .pin_dir_out(pin_dir_out), .strap_rb(strap_rb), .freq_code(freq_code),
    .spread_en(spread_en), .tristate_all(tristate_all), .apic_div2(apic_div2),
    .out_en(out_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    step(); step();
    chk("R3 pads input in reset", 32'(pin_dir_out), 32'd0);
    chk("R1 inverted capture", 32'(strap_rb), 32'b01001);
    chk("R10 code zero", 32'(freq_code), 32'd0);
    chk("R10 spread/tri zero", 32'({spread_en, tristate_all}), 32'd0);
    chk("R10 out_en zero", 32'(out_en), 32'd0);
    chk("R10 apic default half", 32'(apic_div2), 32'd1);
  endtask

  task automatic t_release();
    rst = 1'b0; ctrl_byte = 8'h00;
    step();
    chk("R3 pads drive", 32'(pin_dir_out), 32'd1);
    chk("R4 code from straps", 32'(freq_code), 32'b10110);
    strap_pin = 5'b01010;
    step(); step();
    chk("R2 capture frozen", 32'(strap_rb), 32'b01001);
    chk("R2 code unchanged", 32'(freq_code), 32'b10110);
  endtask

  task automatic t_sw_code();
    ctrl_byte = 8'b1010_1100;
    step();
    chk("R5 software code", 32'(freq_code), 32'b11010);
    ctrl_byte = 8'b0101_1000;
    step();
    chk("R5 software code msb 0", 32'(freq_code), 32'b00101);
    ctrl_byte = 8'b0101_0000;
    step();
    chk("R4 back to straps", 32'(freq_code), 32'b10110);
  endtask

  task automatic t_spread_tri();
    for (int k = 0; k < 4; k++) begin
      ctrl_byte = 8'(k);
      step();
      chk("R6 spread", 32'(spread_en), 32'((k >> 1) & 1));
      chk("R6 tristate", 32'(tristate_all), 32'(k & 1));
    end
    ctrl_byte = 8'h00;
  endtask

  task automatic t_gate();
    out_lvl = 6'b000001; oe_bits = 6'b000001;
    step();
    chk("R7 held while high", 32'(out_en[0]), 32'd0);
    out_lvl = 6'b000000;
    step();
    chk("R7 enable on low", 32'(out_en[0]), 32'd1);
    out_lvl = 6'b000001; oe_bits = 6'b000000;
    step();
    chk("R7 disable held while high", 32'(out_en[0]), 32'd1);
    out_lvl = 6'b000000;
    step();
    chk("R7 disable on low", 32'(out_en[0]), 32'd0);
    oe_bits = 6'b011110;
    step();
    chk("R7 multi enable", 32'(out_en), 32'b111110);
  endtask

  task automatic t_free();
    oe_bits = 6'b000000; out_lvl = 6'b100000;
    step();
    chk("R8 free output runs", 32'(out_en), 32'b100000);
  endtask

  task automatic t_apic();
    apic_half_sel = 1'b0;
    step();
    chk("R9 full rate", 32'(apic_div2), 32'd0);
    apic_half_sel = 1'b1;
    step();
    chk("R9 half rate", 32'(apic_div2), 32'd1);
  endtask

  task automatic t_recapture();
    rst = 1'b1; strap_pin = 5'b00011;
    step();
    chk("R1 recapture in reset", 32'(strap_rb), 32'b11100);
    chk("R3 pads input again", 32'(pin_dir_out), 32'd0);
    chk("R10 out_en cleared", 32'(out_en), 32'd0);
    rst = 1'b0; ctrl_byte = 8'h00; strap_pin = 5'b11111;
    step();
    chk("R4 new strap code", 32'(freq_code), 32'b00011);
    chk("R2 new capture frozen", 32'(strap_rb), 32'b11100);
  endtask

  initial begin
    t_reset_state();
    t_release();
    t_sw_code();
    t_spread_tri();
    t_gate();
    t_free();
    t_apic();
    t_recapture();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule